// File: doc/BRIEF.md
# Crypto Peripheral Interrupt and Access-Violation Unit

This block provides the interrupt and error-reporting logic of a block-cipher peripheral. It has three interrupt sources: data ready, access violation and tag ready. Each source appears at the same bit position in four 32-bit words on the peripheral's register bus. A write-only set word and a write-only clear word change the mask. A read-only mask word shows which sources are enabled. A read-only status word shows which sources are pending. The cipher engine itself lies outside the block. It reports its phase (idle, running, sub-key generation), its configured start mode, and single-cycle pulses that mark a finished data block or a finished tag.

The unit also checks every bus access against the engine phase. An access that is not allowed in that phase sets a sticky violation flag and stores a 4-bit code that names the kind of fault. A software-reset write to the control word is the only thing that clears the flag and the code. The single level interrupt output is high while any source is both pending and enabled.

Top module: `cpiv_irq_unit`

## Requirements
- R1: After reset the mask word, the status word and `irq` are all zero.
- R2: Sources sit at bit 0 (data ready), bit 8 (violation) and bit 16 (tag ready). A 1 written to a bit of the set word (word address 2) sets that mask bit. A 1 written to a bit of the clear word (word address 3) clears it. A 0 bit changes nothing. The mask reads back at word address 4.
- R3: The status word (word address 5) reads data ready at bit 0, the violation flag at bit 8, the violation code in bits 15:12 and tag ready at bit 16. All other bits read 0. Reads of any address other than 4 and 5 return 0 from this block.
- R4: A `data_done` pulse sets data ready. The flag clears when the control word (word address 0) is written with bit 0 (start) or bit 8 (software reset) set, or when an output-data word (word addresses 20 to 23) is read. A set in the same cycle as a clear wins.
- R5: A `tag_done` pulse sets tag ready. Only a software-reset write clears it, and a set in the same cycle wins.
- R6: Phase 1 means running and phase 2 means sub-key generation. These accesses set the flag with the codes shown. An input-data write (word addresses 16 to 19) while running with `start_mode` = 2 gives code 0. An output-data read while running gives code 1. A mode-word (word address 1) write while running gives code 2. An output-data read in sub-key generation gives code 3. A mode-word write in sub-key generation gives code 4.
- R7: A read of any write-only word gives code 5. The write-only words are control 0, set 2, clear 3, key 8 to 15, input data 16 to 19 and IV 24 to 27. Some accesses are legal and raise no flag: mode writes and output reads while idle, input writes while running in another start mode, and status reads in any phase.
- R8: The flag and the code survive every access and event except a software-reset write, which clears both. If several violations occur, the code of the first one is kept.
- R9: `irq` is high exactly when some source is pending and its mask bit is set.
- R10: Writes to the mask and status words are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the mask and status words, 0 elsewhere |
| eng_phase | input | 2 | Engine phase: 0 idle, 1 running, 2 sub-key generation |
| start_mode | input | 2 | Engine start mode as configured |
| data_done | input | 1 | Pulse: block result available |
| tag_done | input | 1 | Pulse: tag available |
| irq | output | 1 | Level interrupt request |

## Verification
On every cycle the assertions check several behaviours. They check that the mask follows set and clear writes, that data ready follows its set pulse and its clear sources, and that tag ready holds. They check that a first violation is captured with the decoder's code, that the flag and code do not move until a software reset, and that an enabled event raises `irq`. The bench's scenarios cover what the assertions cannot see. They drive each violation code with its exact phase, start mode and address, and confirm the legal accesses that must leave the flag clear. They also check the full status word layout, that a second violation leaves the first code in place, and that writes to the read-only words are ignored.

// File: rtl/cpiv_pkg.sv
package cpiv_pkg;
  // interrupt source layout: source i sits at bit i*SRC_STRIDE
  localparam int NSRC       = 3;
  localparam int SRC_STRIDE = 8;
  localparam int IDX_DRDY   = 0;
  localparam int IDX_VIOL   = 1;
  localparam int IDX_TAG    = 2;
  localparam int VT_LSB     = 12;
  localparam int VT_W       = 4;
  localparam int CTL_START  = 0;
  localparam int CTL_SWRST  = 8;

  // word address map
  localparam int unsigned A_CTRL    = 0;
  localparam int unsigned A_MODE    = 1;
  localparam int unsigned A_IEN     = 2;
  localparam int unsigned A_IDIS    = 3;
  localparam int unsigned A_IMASK   = 4;
  localparam int unsigned A_ISTAT   = 5;
  localparam int unsigned KEY_BASE  = 8;
  localparam int unsigned KEY_N     = 8;
  localparam int unsigned BLK_N     = 4;
  localparam int unsigned DIN_BASE  = 16;
  localparam int unsigned DOUT_BASE = DIN_BASE + BLK_N;
  localparam int unsigned IV_BASE   = 24;

  typedef enum logic [1:0] {PH_IDLE = 2'd0, PH_RUN = 2'd1, PH_SUBKEY = 2'd2} phase_e;
  localparam logic [1:0] SMODE_WORD0 = 2'd2;

  typedef enum logic [3:0] {
    RK_NONE, RK_CTRL, RK_MODE, RK_IEN, RK_IDIS, RK_IMASK, RK_ISTAT,
    RK_KEY, RK_DIN, RK_DOUT, RK_IV
  } kind_e;

  typedef struct packed {
    logic            hit;
    logic [VT_W-1:0] code;
  } viol_t;

  function automatic logic in_span(input logic [31:0] a, input int unsigned base,
                                   input int unsigned n);
    return (a >= base) && (a < base + n);
  endfunction

  function automatic kind_e addr_kind(input logic [31:0] a);
    if (a == A_CTRL)                 return RK_CTRL;
    if (a == A_MODE)                 return RK_MODE;
    if (a == A_IEN)                  return RK_IEN;
    if (a == A_IDIS)                 return RK_IDIS;
    if (a == A_IMASK)                return RK_IMASK;
    if (a == A_ISTAT)                return RK_ISTAT;
    if (in_span(a, KEY_BASE, KEY_N))  return RK_KEY;
    if (in_span(a, DIN_BASE, BLK_N))  return RK_DIN;
    if (in_span(a, DOUT_BASE, BLK_N)) return RK_DOUT;
    if (in_span(a, IV_BASE, BLK_N))   return RK_IV;
    return RK_NONE;
  endfunction

  function automatic logic write_only(input kind_e k);
    return k inside {RK_CTRL, RK_IEN, RK_IDIS, RK_KEY, RK_DIN, RK_IV};
  endfunction

  // classify one access against the engine phase
  function automatic viol_t classify(input kind_e k, input logic wr,
                                     input logic [1:0] ph, input logic [1:0] sm);
    viol_t v;
    v = '{hit: 1'b1, code: 4'd0};
    if (wr && k == RK_DIN && ph == PH_RUN && sm == SMODE_WORD0) v.code = 4'd0;
    else if (!wr && k == RK_DOUT && ph == PH_RUN)               v.code = 4'd1;
    else if (wr && k == RK_MODE && ph == PH_RUN)                v.code = 4'd2;
    else if (!wr && k == RK_DOUT && ph == PH_SUBKEY)            v.code = 4'd3;
    else if (wr && k == RK_MODE && ph == PH_SUBKEY)             v.code = 4'd4;
    else if (!wr && write_only(k))                              v.code = 4'd5;
    else v.hit = 1'b0;
    return v;
  endfunction
endpackage

// File: rtl/cpiv_acc_decode.sv
module cpiv_acc_decode
  import cpiv_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic              start_bit,
  input  logic              swrst_bit,
  input  logic [1:0]        phase,
  input  logic [1:0]        smode,
  output logic              start_wr,
  output logic              swrst_wr,
  output logic              ien_wr,
  output logic              idis_wr,
  output logic              dout_rd,
  output logic              mask_rd,
  output logic              stat_rd,
  output logic              viol_hit,
  output logic [VT_W-1:0]   viol_code
);
  logic [31:0] a32;
  kind_e       kind;
  viol_t       v;

  assign a32  = 32'(addr);
  assign kind = addr_kind(a32);
  assign v    = classify(kind, we, phase, smode);

  assign start_wr  = sel && we && kind == RK_CTRL && start_bit;
  assign swrst_wr  = sel && we && kind == RK_CTRL && swrst_bit;
  assign ien_wr    = sel && we && kind == RK_IEN;
  assign idis_wr   = sel && we && kind == RK_IDIS;
  assign dout_rd   = sel && !we && kind == RK_DOUT;
  assign mask_rd   = sel && !we && kind == RK_IMASK;
  assign stat_rd   = sel && !we && kind == RK_ISTAT;
  assign viol_hit  = sel && v.hit;
  assign viol_code = v.code;
endmodule

// File: rtl/cpiv_viol_trap.sv
module cpiv_viol_trap #(
  parameter int VT_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit,
  input  logic [VT_W-1:0] code,
  input  logic            swrst,
  output logic            flag,
  output logic [VT_W-1:0] vtype
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      vtype <= '0;
    end else if (swrst) begin
      flag  <= 1'b0;
      vtype <= '0;
    end else if (hit && !flag) begin
      flag  <= 1'b1;
      vtype <= code;
    end
  end
endmodule

// File: rtl/cpiv_mask_reg.sv
module cpiv_mask_reg #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_wr,
  input  logic            clr_wr,
  input  logic [NSRC-1:0] wbits,
  output logic [NSRC-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= '0;
    else if (set_wr) mask_q <= mask_q | wbits;
    else if (clr_wr) mask_q <= mask_q & ~wbits;
  end
endmodule

// File: rtl/cpiv_evt_status.sv
module cpiv_evt_status #(
  parameter int NEV = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NEV-1:0] set_pls,
  input  logic [NEV-1:0] clr_pls,
  output logic [NEV-1:0] q
);
  for (genvar i = 0; i < NEV; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q[i] <= 1'b0;
      else if (set_pls[i]) q[i] <= 1'b1;
      else if (clr_pls[i]) q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/cpiv_irq_unit.sv
module cpiv_irq_unit
  import cpiv_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [1:0]        eng_phase,
  input  logic [1:0]        start_mode,
  input  logic              data_done,
  input  logic              tag_done,
  output logic              irq
);
  localparam int NEV = 2;

  logic            start_wr, swrst_wr, ien_wr, idis_wr, dout_rd, mask_rd, stat_rd;
  logic            viol_hit, viol_flag;
  logic [VT_W-1:0] viol_code, viol_type;
  logic [NSRC-1:0] wbits, mask_q, stat_w;
  logic [NEV-1:0]  evt_set, evt_clr, evt_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_wbits
    assign wbits[i] = bus_wdata[i*SRC_STRIDE];
  end

  cpiv_acc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .start_bit(bus_wdata[CTL_START]), .swrst_bit(bus_wdata[CTL_SWRST]),
    .phase(eng_phase), .smode(start_mode),
    .start_wr(start_wr), .swrst_wr(swrst_wr), .ien_wr(ien_wr), .idis_wr(idis_wr),
    .dout_rd(dout_rd), .mask_rd(mask_rd), .stat_rd(stat_rd),
    .viol_hit(viol_hit), .viol_code(viol_code)
  );

  cpiv_viol_trap #(.VT_W(VT_W)) u_trap (
    .clk(clk), .rst_n(rst_n), .hit(viol_hit), .code(viol_code),
    .swrst(swrst_wr), .flag(viol_flag), .vtype(viol_type)
  );

  cpiv_mask_reg #(.NSRC(NSRC)) u_mask (
    .clk(clk), .rst_n(rst_n), .set_wr(ien_wr), .clr_wr(idis_wr),
    .wbits(wbits), .mask_q(mask_q)
  );

  // event bit 0: data ready, event bit 1: tag ready
  assign evt_set = {tag_done, data_done};
  assign evt_clr = {swrst_wr, start_wr | swrst_wr | dout_rd};

  cpiv_evt_status #(.NEV(NEV)) u_evt (
    .clk(clk), .rst_n(rst_n), .set_pls(evt_set), .clr_pls(evt_clr), .q(evt_q)
  );

  always_comb begin
    stat_w           = '0;
    stat_w[IDX_DRDY] = evt_q[0];
    stat_w[IDX_VIOL] = viol_flag;
    stat_w[IDX_TAG]  = evt_q[1];
  end

  assign irq = |(stat_w & mask_q);

  always_comb begin
    bus_rdata = '0;
    if (mask_rd) begin
      for (int i = 0; i < NSRC; i++) bus_rdata[i*SRC_STRIDE] = mask_q[i];
    end else if (stat_rd) begin
      for (int i = 0; i < NSRC; i++) bus_rdata[i*SRC_STRIDE] = stat_w[i];
      bus_rdata[VT_LSB +: VT_W] = viol_type;
    end
  end
endmodule

// File: rtl/cpiv_irq_unit_chk.sv
module cpiv_irq_unit_chk #(
  parameter int NSRC = 3,
  parameter int VT_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ev_data,
  input logic            start_wr,
  input logic            swrst_wr,
  input logic            dout_rd,
  input logic            ien_wr,
  input logic            idis_wr,
  input logic [NSRC-1:0] wbits,
  input logic [NSRC-1:0] mask_q,
  input logic            drdy,
  input logic            tagr,
  input logic            viol_hit,
  input logic [VT_W-1:0] viol_code,
  input logic            viol_flag,
  input logic [VT_W-1:0] viol_type,
  input logic            irq
);
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask_q == '0 && !irq && !viol_flag));

  p_mask_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_wr && wbits[0]) |=> mask_q[0]);

  p_mask_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (idis_wr && wbits[NSRC-1]) |=> !mask_q[NSRC-1]);

  p_drdy_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_data |=> drdy);

  p_drdy_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((dout_rd || start_wr || swrst_wr) && !ev_data) |=> !drdy);

  p_tag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tagr && !swrst_wr) |=> tagr);

  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_hit && !viol_flag && !swrst_wr) |=> (viol_flag && viol_type == $past(viol_code)));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !swrst_wr) |=> (viol_flag && $stable(viol_type)));

  p_swrst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    swrst_wr |=> (!viol_flag && viol_type == '0));

  p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data && mask_q[0] && !idis_wr) |=> irq);
endmodule

bind cpiv_irq_unit cpiv_irq_unit_chk #(.NSRC(cpiv_pkg::NSRC), .VT_W(cpiv_pkg::VT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_data(data_done), .start_wr(start_wr),
  .swrst_wr(swrst_wr), .dout_rd(dout_rd), .ien_wr(ien_wr), .idis_wr(idis_wr),
  .wbits(wbits), .mask_q(mask_q), .drdy(evt_q[0]), .tagr(evt_q[1]),
  .viol_hit(viol_hit), .viol_code(viol_code), .viol_flag(viol_flag),
  .viol_type(viol_type), .irq(irq)
);

// File: tb/test_cpiv_irq_unit.sv
module test_cpiv_irq_unit;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        b_sel = 1'b0, b_we = 1'b0;
  logic [5:0]  b_addr = '0;
  logic [31:0] b_wd = '0;
  logic [31:0] b_rd;
  logic [1:0]  ph = 2'd0, sm = 2'd0;
  logic        evd = 1'b0, evt = 1'b0;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  cpiv_irq_unit i_cpiv_irq_unit (
    .clk(clk), .rst_n(rst_n), .bus_sel(b_sel), .bus_we(b_we), .bus_addr(b_addr),
    .bus_wdata(b_wd), .bus_rdata(b_rd), .eng_phase(ph), .start_mode(sm),
    .data_done(evd), .tag_done(evt), .irq(irq)
  );

  // behavioural reference model
  logic [31:0] m_mask;
  bit          m_dr, m_tag, m_vf;
  int          m_vt;

  function automatic bit is_wo(int a);
    return a == 0 || a == 2 || a == 3 || (a >= 8 && a <= 19) || (a >= 24 && a <= 27);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = 0; m_dr = 0; m_tag = 0; m_vf = 0; m_vt = 0;
    end else begin
      bit wr, rd, st, swr, odr;
      int a, code;
      a   = int'(b_addr);
      wr  = b_sel && b_we;
      rd  = b_sel && !b_we;
      st  = wr && a == 0 && b_wd[0];
      swr = wr && a == 0 && b_wd[8];
      odr = rd && a >= 20 && a <= 23;
      if (wr && a == 2) m_mask = m_mask | (b_wd & 32'h0001_0101);
      if (wr && a == 3) m_mask = m_mask & ~(b_wd & 32'h0001_0101);
      code = -1;
      if (wr && a >= 16 && a <= 19 && ph == 1 && sm == 2) code = 0;
      else if (odr && ph == 1)                            code = 1;
      else if (wr && a == 1 && ph == 1)                   code = 2;
      else if (odr && ph == 2)                            code = 3;
      else if (wr && a == 1 && ph == 2)                   code = 4;
      else if (rd && is_wo(a))                            code = 5;
      if (swr) begin m_vf = 0; m_vt = 0; end
      else if (code >= 0 && !m_vf) begin m_vf = 1; m_vt = code; end
      if (evd) m_dr = 1; else if (st || swr || odr) m_dr = 0;
      if (evt) m_tag = 1; else if (swr) m_tag = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // R9: irq compared to the model on every clock
  always @(negedge clk) begin
    if (rst_n) begin
      bit e;
      e = (m_dr && m_mask[0]) || (m_vf && m_mask[8]) || (m_tag && m_mask[16]);
      chk("R9 irq vs model", {31'b0, irq}, {31'b0, e});
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); b_sel = 1; b_we = 1; b_addr = 6'(a); b_wd = d;
    @(negedge clk); b_sel = 0; b_we = 0; b_wd = 0;
  endtask

  task automatic wr_ev(input int a, input logic [31:0] d);
    @(negedge clk); b_sel = 1; b_we = 1; b_addr = 6'(a); b_wd = d; evd = 1;
    @(negedge clk); b_sel = 0; b_we = 0; b_wd = 0; evd = 0;
  endtask

  task automatic rd(input int a, input string req, input logic [31:0] exp);
    @(negedge clk); b_sel = 1; b_we = 0; b_addr = 6'(a);
    #1 chk(req, b_rd, exp);
    @(negedge clk); b_sel = 0;
  endtask

  task automatic pulse(input bit d, input bit t);
    @(negedge clk); evd = d; evt = t;
    @(negedge clk); evd = 0; evt = 0;
  endtask

  task automatic chk_irq(input string req, input bit exp);
    @(negedge clk); #1 chk(req, {31'b0, irq}, {31'b0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(4, "R1 mask after reset", 32'h0);
    rd(5, "R1 status after reset", 32'h0);
    chk_irq("R1 irq after reset", 0);

    // R2 mask set/clear, R10 read-only words ignore writes
    wr(2, 32'h0001_0101);
    rd(4, "R2 mask after set", 32'h0001_0101);
    wr(3, 32'h0000_0100);
    rd(4, "R2 mask after clear", 32'h0001_0001);
    wr(2, 32'h0);
    rd(4, "R2 zero set leaves mask", 32'h0001_0001);
    wr(4, 32'hFFFF_FFFF);
    rd(4, "R10 mask write ignored", 32'h0001_0001);
    wr(5, 32'hFFFF_FFFF);
    rd(5, "R10 status write ignored", 32'h0);
    rd(1, "R3 other address reads 0", 32'h0);

    // R4 data ready sources
    pulse(1, 0);
    rd(5, "R4 data ready set", 32'h1);
    chk_irq("R9 irq from data ready", 1);
    wr(0, 32'h1);
    rd(5, "R4 start clears", 32'h0);
    pulse(1, 0);
    rd(20, "R4 output read value", 32'h0);
    rd(5, "R4 output read clears", 32'h0);
    pulse(1, 0);
    wr(0, 32'h100);
    rd(5, "R4 swrst clears", 32'h0);
    wr_ev(0, 32'h1);
    rd(5, "R4 set wins over start", 32'h1);
    wr(0, 32'h1);

    // R5 tag ready
    pulse(0, 1);
    rd(5, "R5 tag set", 32'h0001_0000);
    chk_irq("R9 irq from tag", 1);
    wr(0, 32'h1);
    rd(5, "R5 start leaves tag", 32'h0001_0000);
    wr(0, 32'h100);
    rd(5, "R5 swrst clears tag", 32'h0);
    chk_irq("R9 irq low", 0);

    // R6 violation codes
    ph = 1; sm = 2; wr(16, 32'hA5); rd(5, "R6 code0", 32'h0000_0100); wr(0, 32'h100);
    ph = 1; sm = 0; rd(21, "R6 out read value", 32'h0); rd(5, "R6 code1", 32'h0000_1100); wr(0, 32'h100);
    ph = 1; wr(1, 32'h3); rd(5, "R6 code2", 32'h0000_2100); wr(0, 32'h100);
    ph = 2; rd(23, "R6 out read value", 32'h0); rd(5, "R6 code3", 32'h0000_3100); wr(0, 32'h100);
    ph = 2; wr(1, 32'h3); rd(5, "R6 code4", 32'h0000_4100); wr(0, 32'h100);

    // R7 write-only reads and legal accesses
    ph = 0; rd(26, "R7 iv read value", 32'h0); rd(5, "R7 iv read code5", 32'h0000_5100); wr(0, 32'h100);
    rd(0, "R7 ctrl read value", 32'h0); rd(5, "R7 ctrl read code5", 32'h0000_5100); wr(0, 32'h100);
    rd(9, "R7 key read value", 32'h0); rd(5, "R7 key read code5", 32'h0000_5100); wr(0, 32'h100);
    ph = 1; sm = 0; wr(17, 32'h1); rd(5, "R7 input write other mode legal", 32'h0);
    ph = 0; wr(1, 32'h7); rd(5, "R7 mode write idle legal", 32'h0);
    ph = 0; rd(22, "R7 out read idle value", 32'h0); rd(5, "R7 out read idle legal", 32'h0);
    ph = 1; sm = 2; rd(5, "R7 status read running legal", 32'h0);

    // R8 sticky, first code kept; R9 irq from violation
    wr(2, 32'h100);
    ph = 1; rd(20, "R8 out read value", 32'h0);
    chk_irq("R9 irq from violation", 1);
    ph = 2; wr(1, 32'h1);
    rd(5, "R8 first code kept", 32'h0000_1100);
    ph = 0; wr(0, 32'h1); pulse(0, 0);
    rd(5, "R8 start leaves flag", 32'h0000_1100);
    wr(0, 32'h100);
    rd(5, "R8 swrst clears flag", 32'h0);
    chk_irq("R9 irq after swrst", 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule